// File: doc/BRIEF.md
# Programmable Video Sync Pulse Generator

This block rebuilds the timing pulses of a video line from a free-running position counter clocked at the 4X reference clock. The counter advances two ticks per pixel, wraps at the end of each line and steps a line counter. From these two counts the block decodes five pulses: composite sync, horizontal blanking, vertical blanking, a sync-tip clamp and a burst gate. The burst gate can be made longer so that it works as a back-porch clamp.

The line length comes from an 11-bit field P. One line lasts P + 1024 ticks, which means P = 2 × pixels − 1024. When P is zero, the built-in default for the selected standard applies: 858 pixels and 525 lines, or 864 pixels and 625 lines. Composite sync can be taken from a raw separated-sync input instead of the internal generator. The sync-tip clamp can be timed from the rising edge of that raw input instead of the regenerated line start. Each output group has its own polarity bit. All outputs come from registers.

The interface is made of plain control pins. No data stream passes through it, so it has no valid/ready handshake. Configuration is expected to stay static while the block runs and to change only under reset.

Top module: `vspg_top`

## Requirements
- R1: With P ≠ 0, a line lasts P + 1024 clock ticks. The position counter runs 0 … P+1023 and then returns to 0.
- R2: With P = 0, a line lasts 2 × NTSC_PIX ticks (1716 by default) when std_pal = 0, and 2 × PAL_PIX ticks (1728 by default) when std_pal = 1. A frame is NTSC_LINES or PAL_LINES lines long.
- R3: pol_csync = 1 makes csync_out high when active. pol_csync = 0 makes it low when active.
- R4: pol_blank sets the active level of both hblank_out and vblank_out in the same way (1 = high active, 0 = low active).
- R5: pol_clamp sets the active level of both sclamp_out and burst_out in the same way.
- R6: vblank_out is active on lines 0 … 8 when vbl_long = 0, and on lines 0 … 15 when vbl_long = 1.
- R7: With csync_src_raw = 0, composite sync is active for positions 0 … 127 on ordinary lines. On lines 3 … 5 it is active for positions 0 … L−129, where L is the line length, which gives broad pulses. With csync_src_raw = 1, csync_out follows raw_sync (1 = sync) with a delay of two clocks.
- R8: With clamp_src_raw = 0, the sync-tip clamp is active for positions 16 … 79. With clamp_src_raw = 1, take A as the clock edge that first samples raw_sync high after it was low. The clamp is then active in the output after edges A+18 through A+81. It is inactive from reset until the first such rising edge.
- R9: The burst gate is active from position 152 for 64 ticks when burst_long = 0, and for 128 ticks when burst_long = 1.
- R10: hblank_out is active for positions 0 … 279 and for the last 24 positions of every line.
- R11: A high line_start sampled at a clock edge sets the position to 0 at that edge and advances the line counter, exactly like a natural wrap.
- R12: While rst_n is low, position and line are 0 and every output sits at its inactive level as set by its polarity bit.
- R13: Each output reflects the position and line held one clock earlier, so all outputs change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4X reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_sync | input | 1 | Raw separated composite sync, 1 = sync |
| line_start | input | 1 | Strobe that restarts the line |
| std_pal | input | 1 | 0 = 525-line default, 1 = 625-line default |
| pix_len | input | 11 | Line length field P, 0 = standard default |
| vbl_long | input | 1 | 0 = 9 blanked lines, 1 = 16 |
| burst_long | input | 1 | 0 = 64-tick burst gate, 1 = 128-tick |
| csync_src_raw | input | 1 | 1 = composite sync from raw_sync |
| clamp_src_raw | input | 1 | 1 = sync-tip clamp timed from raw_sync edge |
| pol_csync | input | 1 | Composite sync active level |
| pol_blank | input | 1 | Blanking outputs active level |
| pol_clamp | input | 1 | Clamp and burst outputs active level |
| csync_out | output | 1 | Composite sync |
| hblank_out | output | 1 | Horizontal blanking |
| vblank_out | output | 1 | Vertical blanking |
| sclamp_out | output | 1 | Sync-tip clamp |
| burst_out | output | 1 | Burst gate / back-porch clamp |

## Verification
The bench keeps the default pixel counts but builds the block with NTSC_LINES = 20 and PAL_LINES = 24. At these values complete frames, including every wrap of the line counter and the broad-pulse lines, fit within a few tens of thousands of cycles. Both default line lengths, a programmed length (P = 100), both blanking lengths, both burst lengths and all polarity combinations are therefore run over whole frames, and each cycle is compared against an independent model. The raw-source paths are driven with a periodic raw sync whose period is not a multiple of the line length. This exercises the edge-timed clamp window and its saturation independently of the line counter.

// File: rtl/vspg_pkg.sv
package vspg_pkg;
  typedef struct packed {
    logic csync;
    logic hblank;
    logic vblank;
    logic sclamp;
    logic burst;
  } vspg_act_t;
endpackage

// File: rtl/vspg_line_timer.sv
module vspg_line_timer #(
  parameter int PIX_W      = 11,
  parameter int NTSC_PIX   = 858,
  parameter int PAL_PIX    = 864,
  parameter int NTSC_LINES = 525,
  parameter int PAL_LINES  = 625,
  localparam int CNT_W     = PIX_W + 1,
  localparam int MAX_LINES = (NTSC_LINES > PAL_LINES) ? NTSC_LINES : PAL_LINES,
  localparam int LINE_W    = $clog2(MAX_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              std_pal,
  input  logic [PIX_W-1:0]  pix_len,
  output logic [CNT_W-1:0]  pos,
  output logic [CNT_W-1:0]  ticks,
  output logic [LINE_W-1:0] line
);
  localparam logic [CNT_W-1:0] BASE_T  = CNT_W'(1 << (PIX_W - 1));
  localparam logic [CNT_W-1:0] NTSC_T  = CNT_W'(2 * NTSC_PIX);
  localparam logic [CNT_W-1:0] PAL_T   = CNT_W'(2 * PAL_PIX);
  localparam logic [LINE_W-1:0] NTSC_L = LINE_W'(NTSC_LINES - 1);
  localparam logic [LINE_W-1:0] PAL_L  = LINE_W'(PAL_LINES - 1);

  logic [LINE_W-1:0] last_line;
  logic              wrap;

  always_comb begin
    if (pix_len == '0) ticks = std_pal ? PAL_T : NTSC_T;
    else               ticks = {1'b0, pix_len} + BASE_T;
    last_line = std_pal ? PAL_L : NTSC_L;
    wrap      = line_start || (pos >= ticks - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      line <= '0;
    end else if (wrap) begin
      pos  <= '0;
      line <= (line >= last_line) ? '0 : line + LINE_W'(1);
    end else begin
      pos <= pos + CNT_W'(1);
    end
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos >= ticks - CNT_W'(1)) |=> (pos == '0));
  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (pos == '0));
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && (pos < ticks - CNT_W'(1))) |=> (pos == $past(pos) + CNT_W'(1)));
endmodule

// File: rtl/vspg_raw_track.sv
module vspg_raw_track #(
  parameter int CLAMP_OFS = 16,
  parameter int CLAMP_W   = 64,
  localparam int RMAX     = CLAMP_OFS + CLAMP_W,
  localparam int RAW_W    = $clog2(RMAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_sync,
  output logic raw_q,
  output logic raw_clamp
);
  localparam logic [RAW_W-1:0] R_MAX = RAW_W'(RMAX);
  localparam logic [RAW_W-1:0] R_OFS = RAW_W'(CLAMP_OFS);

  logic             raw_d;
  logic [RAW_W-1:0] rcnt;
  logic             rise;

  assign rise      = raw_q && !raw_d;
  assign raw_clamp = (rcnt >= R_OFS) && (rcnt < R_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      raw_d <= 1'b0;
      rcnt  <= R_MAX;
    end else begin
      raw_q <= raw_sync;
      raw_d <= raw_q;
      if (rise)               rcnt <= '0;
      else if (rcnt != R_MAX) rcnt <= rcnt + RAW_W'(1);
    end
  end

  assert_edge_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (rcnt == '0));
  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && rcnt == R_MAX) |=> (rcnt == R_MAX));
endmodule

// File: rtl/vspg_pulse_decode.sv
module vspg_pulse_decode
  import vspg_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int LINE_W      = 10,
  parameter int SYNC_W      = 128,
  parameter int CLAMP_OFS   = 16,
  parameter int CLAMP_W     = 64,
  parameter int BURST_OFS   = 152,
  parameter int BURST_SHORT = 64,
  parameter int BURST_LONG  = 128,
  parameter int HBLANK_W    = 280,
  parameter int FRONT_W     = 24,
  parameter int VBL_SHORT   = 9,
  parameter int VBL_LONG    = 16,
  parameter int VS_FIRST    = 3,
  parameter int VS_LAST     = 5
) (
  input  logic [CNT_W-1:0]  pos,
  input  logic [CNT_W-1:0]  ticks,
  input  logic [LINE_W-1:0] line,
  input  logic              vbl_long,
  input  logic              burst_long,
  output vspg_act_t         act
);
  localparam logic [CNT_W-1:0]  SYNC_T  = CNT_W'(SYNC_W);
  localparam logic [CNT_W-1:0]  CL_S    = CNT_W'(CLAMP_OFS);
  localparam logic [CNT_W-1:0]  CL_E    = CNT_W'(CLAMP_OFS + CLAMP_W);
  localparam logic [CNT_W-1:0]  BU_S    = CNT_W'(BURST_OFS);
  localparam logic [CNT_W-1:0]  BU_ES   = CNT_W'(BURST_OFS + BURST_SHORT);
  localparam logic [CNT_W-1:0]  BU_EL   = CNT_W'(BURST_OFS + BURST_LONG);
  localparam logic [CNT_W-1:0]  HB_T    = CNT_W'(HBLANK_W);
  localparam logic [CNT_W-1:0]  FP_T    = CNT_W'(FRONT_W);
  localparam logic [LINE_W-1:0] VB_S    = LINE_W'(VBL_SHORT);
  localparam logic [LINE_W-1:0] VB_L    = LINE_W'(VBL_LONG);
  localparam logic [LINE_W-1:0] VS_A    = LINE_W'(VS_FIRST);
  localparam logic [LINE_W-1:0] VS_B    = LINE_W'(VS_LAST);

  logic vs_line;

  always_comb begin
    vs_line    = (line >= VS_A) && (line <= VS_B);
    act.csync  = vs_line ? (pos < ticks - SYNC_T) : (pos < SYNC_T);
    act.hblank = (pos < HB_T) || (pos >= ticks - FP_T);
    act.vblank = line < (vbl_long ? VB_L : VB_S);
    act.sclamp = (pos >= CL_S) && (pos < CL_E);
    act.burst  = (pos >= BU_S) && (pos < (burst_long ? BU_EL : BU_ES));
  end
endmodule

// File: rtl/vspg_top.sv
module vspg_top
  import vspg_pkg::*;
#(
  parameter int PIX_W       = 11,
  parameter int NTSC_PIX    = 858,
  parameter int PAL_PIX     = 864,
  parameter int NTSC_LINES  = 525,
  parameter int PAL_LINES   = 625,
  parameter int SYNC_W      = 128,
  parameter int CLAMP_OFS   = 16,
  parameter int CLAMP_W     = 64,
  parameter int BURST_OFS   = 152,
  parameter int BURST_SHORT = 64,
  parameter int BURST_LONG  = 128,
  parameter int HBLANK_W    = 280,
  parameter int FRONT_W     = 24,
  parameter int VBL_SHORT   = 9,
  parameter int VBL_LONG    = 16,
  parameter int VS_FIRST    = 3,
  parameter int VS_LAST     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_sync,
  input  logic             line_start,
  input  logic             std_pal,
  input  logic [PIX_W-1:0] pix_len,
  input  logic             vbl_long,
  input  logic             burst_long,
  input  logic             csync_src_raw,
  input  logic             clamp_src_raw,
  input  logic             pol_csync,
  input  logic             pol_blank,
  input  logic             pol_clamp,
  output logic             csync_out,
  output logic             hblank_out,
  output logic             vblank_out,
  output logic             sclamp_out,
  output logic             burst_out
);
  localparam int CNT_W     = PIX_W + 1;
  localparam int MAX_LINES = (NTSC_LINES > PAL_LINES) ? NTSC_LINES : PAL_LINES;
  localparam int LINE_W    = $clog2(MAX_LINES);

  logic [CNT_W-1:0]  pos, ticks;
  logic [LINE_W-1:0] line;
  logic              raw_q, raw_clamp;
  vspg_act_t         regen, sel;
  logic              past_ok;

  vspg_line_timer #(
    .PIX_W(PIX_W), .NTSC_PIX(NTSC_PIX), .PAL_PIX(PAL_PIX),
    .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .std_pal(std_pal),
    .pix_len(pix_len), .pos(pos), .ticks(ticks), .line(line)
  );

  vspg_raw_track #(.CLAMP_OFS(CLAMP_OFS), .CLAMP_W(CLAMP_W)) u_raw (
    .clk(clk), .rst_n(rst_n), .raw_sync(raw_sync),
    .raw_q(raw_q), .raw_clamp(raw_clamp)
  );

  vspg_pulse_decode #(
    .CNT_W(CNT_W), .LINE_W(LINE_W), .SYNC_W(SYNC_W),
    .CLAMP_OFS(CLAMP_OFS), .CLAMP_W(CLAMP_W), .BURST_OFS(BURST_OFS),
    .BURST_SHORT(BURST_SHORT), .BURST_LONG(BURST_LONG),
    .HBLANK_W(HBLANK_W), .FRONT_W(FRONT_W), .VBL_SHORT(VBL_SHORT),
    .VBL_LONG(VBL_LONG), .VS_FIRST(VS_FIRST), .VS_LAST(VS_LAST)
  ) u_decode (
    .pos(pos), .ticks(ticks), .line(line), .vbl_long(vbl_long),
    .burst_long(burst_long), .act(regen)
  );

  always_comb begin
    sel        = regen;
    sel.csync  = csync_src_raw ? raw_q : regen.csync;
    sel.sclamp = clamp_src_raw ? raw_clamp : regen.sclamp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csync_out  <= ~pol_csync;
      hblank_out <= ~pol_blank;
      vblank_out <= ~pol_blank;
      sclamp_out <= ~pol_clamp;
      burst_out  <= ~pol_clamp;
      past_ok    <= 1'b0;
    end else begin
      csync_out  <= sel.csync  ~^ pol_csync;
      hblank_out <= sel.hblank ~^ pol_blank;
      vblank_out <= sel.vblank ~^ pol_blank;
      sclamp_out <= sel.sclamp ~^ pol_clamp;
      burst_out  <= sel.burst  ~^ pol_clamp;
      past_ok    <= 1'b1;
    end
  end

  assert_raw_csync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(csync_src_raw) && $stable(pol_csync))
      |-> (csync_out == ($past(raw_q) ~^ pol_csync)));
  assert_vblank_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $stable(pol_blank) && $stable(vbl_long) && $past(line) >= LINE_W'(VBL_LONG))
      |-> (vblank_out == ~pol_blank));
  assert_clamp_burst_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $stable(pol_clamp) && !$past(clamp_src_raw))
      |-> !((sclamp_out == pol_clamp) && (burst_out == pol_clamp)));
endmodule

// File: tb/vspg_top_bench.sv
module vspg_top_bench;
  localparam int NL = 20;
  localparam int PL = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_sync = 1'b0, line_start = 1'b0, std_pal = 1'b0;
  logic [10:0] pix_len = '0;
  logic vbl_long = 0, burst_long = 0, csync_src_raw = 0, clamp_src_raw = 0;
  logic pol_csync = 1, pol_blank = 1, pol_clamp = 1;
  logic csync_out, hblank_out, vblank_out, sclamp_out, burst_out;

  int total = 0, bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  vspg_top #(.NTSC_LINES(NL), .PAL_LINES(PL)) u_vspg_top (
    .clk(clk), .rst_n(rst_n), .raw_sync(raw_sync), .line_start(line_start),
    .std_pal(std_pal), .pix_len(pix_len), .vbl_long(vbl_long),
    .burst_long(burst_long), .csync_src_raw(csync_src_raw),
    .clamp_src_raw(clamp_src_raw), .pol_csync(pol_csync),
    .pol_blank(pol_blank), .pol_clamp(pol_clamp), .csync_out(csync_out),
    .hblank_out(hblank_out), .vblank_out(vblank_out),
    .sclamp_out(sclamp_out), .burst_out(burst_out)
  );

  // Reference model built from the requirements (R1, R2, R6-R11, R13)
  int m_pos, m_line, m_rc;
  logic m_r1, m_r2;
  logic e_cs, e_hb, e_vb, e_sc, e_bu;

  function automatic int line_len();
    if (pix_len != 0) return int'(pix_len) + 1024;
    return std_pal ? 1728 : 1716;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos <= 0; m_line <= 0; m_rc <= 80; m_r1 <= 0; m_r2 <= 0;
      e_cs <= ~pol_csync; e_hb <= ~pol_blank; e_vb <= ~pol_blank;
      e_sc <= ~pol_clamp; e_bu <= ~pol_clamp;
    end else begin
      automatic int  L = line_len();
      automatic bit  vs = (m_line >= 3 && m_line <= 5);
      automatic bit  cs = csync_src_raw ? m_r1 : (vs ? (m_pos < L - 128) : (m_pos < 128));
      automatic bit  sc = clamp_src_raw ? (m_rc >= 16 && m_rc < 80) : (m_pos >= 16 && m_pos < 80);
      automatic bit  bu = (m_pos >= 152) && (m_pos < (burst_long ? 280 : 216));
      e_cs <= pol_csync ? cs : !cs;
      e_hb <= pol_blank ? (m_pos < 280 || m_pos >= L - 24) : !(m_pos < 280 || m_pos >= L - 24);
      e_vb <= pol_blank ? (m_line < (vbl_long ? 16 : 9)) : !(m_line < (vbl_long ? 16 : 9));
      e_sc <= pol_clamp ? sc : !sc;
      e_bu <= pol_clamp ? bu : !bu;
      if (line_start || m_pos == L - 1) begin
        m_pos  <= 0;
        m_line <= (m_line == (std_pal ? PL : NL) - 1) ? 0 : m_line + 1;
      end else m_pos <= m_pos + 1;
      m_r1 <= raw_sync; m_r2 <= m_r1;
      if (m_r1 && !m_r2) m_rc <= 0;
      else if (m_rc != 80) m_rc <= m_rc + 1;
    end
  end

  // Per-cycle comparison monitor
  logic mon_en = 0;
  int   n_cs, n_hb, n_vb, n_sc, n_bu;
  logic f_cs, f_hb, f_vb, f_sc, f_bu;
  int   gap, last_rise;
  logic prev_bu;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_en) begin
      if (csync_out  !== e_cs) begin if (n_cs == 0) f_cs = csync_out;  n_cs++; end
      if (hblank_out !== e_hb) begin if (n_hb == 0) f_hb = hblank_out; n_hb++; end
      if (vblank_out !== e_vb) begin if (n_vb == 0) f_vb = vblank_out; n_vb++; end
      if (sclamp_out !== e_sc) begin if (n_sc == 0) f_sc = sclamp_out; n_sc++; end
      if (burst_out  !== e_bu) begin if (n_bu == 0) f_bu = burst_out;  n_bu++; end
      if ((burst_out == pol_clamp) && !prev_bu) begin
        gap = cyc - last_rise; last_rise = cyc;
      end
      prev_bu = (burst_out == pol_clamp);
    end
  end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic report(input string tag, input int n, input logic got);
    total++;
    if (n != 0) begin
      bad++;
      $display("FAIL %s mismatches=%0d first got=%b exp=%b", tag, n, got, ~got);
    end
  endtask

  task automatic start_run();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cs = 0; n_hb = 0; n_vb = 0; n_sc = 0; n_bu = 0;
    gap = 0; last_rise = cyc; prev_bu = 1'b1;
    rst_n = 1'b1;
    mon_en = 1'b1;
  endtask

  task automatic finish_run(input string name);
    mon_en = 1'b0;
    report({name, " R3 R7 csync"},  n_cs, f_cs);
    report({name, " R4 R10 hblank"}, n_hb, f_hb);
    report({name, " R4 R6 vblank"},  n_vb, f_vb);
    report({name, " R5 R8 sclamp"},  n_sc, f_sc);
    report({name, " R5 R9 burst"},   n_bu, f_bu);
  endtask

  // R12: reset state follows polarity
  task automatic t_reset();
    rst_n = 0; pol_csync = 0; pol_blank = 1; pol_clamp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(csync_out == 1 && sclamp_out == 1 && burst_out == 1, "R12 reset low-active group",
          {csync_out, sclamp_out, burst_out}, 7);
    check(hblank_out == 0 && vblank_out == 0, "R12 reset high-active blanks",
          {hblank_out, vblank_out}, 0);
  endtask

  // R2: 525-line default length, all high active, short blanking and burst
  task automatic t_ntsc_default();
    std_pal = 0; pix_len = 0; vbl_long = 0; burst_long = 0;
    csync_src_raw = 0; clamp_src_raw = 0;
    pol_csync = 1; pol_blank = 1; pol_clamp = 1;
    start_run();
    repeat (1716 * NL + 50) @(negedge clk);
    finish_run("ntsc");
    check(gap == 1716, "R2 ntsc line period", gap, 1716);
  endtask

  // R2, R6, R9: 625-line default, long blanking and burst, all low active
  task automatic t_pal_long();
    std_pal = 1; pix_len = 0; vbl_long = 1; burst_long = 1;
    csync_src_raw = 0; clamp_src_raw = 0;
    pol_csync = 0; pol_blank = 0; pol_clamp = 0;
    start_run();
    repeat (1728 * PL + 50) @(negedge clk);
    finish_run("pal");
    check(gap == 1728, "R2 pal line period", gap, 1728);
  endtask

  // R1, R7, R8: programmed length with raw sync and raw clamp source
  task automatic t_prog_raw();
    std_pal = 0; pix_len = 11'd100; vbl_long = 0; burst_long = 0;
    csync_src_raw = 1; clamp_src_raw = 1;
    pol_csync = 1; pol_blank = 0; pol_clamp = 1;
    start_run();
    for (int i = 0; i < 1124 * NL + 50; i++) begin
      raw_sync = ((i % 700) < 45) && (i > 30);
      @(negedge clk);
    end
    raw_sync = 0;
    finish_run("prog");
    check(gap == 1124, "R1 programmed line period", gap, 1124);
  endtask

  // R11: line restart strobe
  task automatic t_restart();
    std_pal = 0; pix_len = 0; vbl_long = 0; burst_long = 1;
    csync_src_raw = 0; clamp_src_raw = 0;
    pol_csync = 1; pol_blank = 1; pol_clamp = 1;
    start_run();
    repeat (700) @(negedge clk);
    line_start = 1; @(negedge clk); line_start = 0;
    @(negedge clk);
    check(hblank_out == 1, "R11 blank after restart", hblank_out, 1);
    repeat (2500) @(negedge clk);
    line_start = 1; @(negedge clk); line_start = 0;
    repeat (400) @(negedge clk);
    finish_run("restart R11");
  endtask

  initial begin
    t_reset();
    t_ntsc_default();
    t_pal_long();
    t_prog_raw();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired got=%0d exp=%0d", 180000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule